// File: doc/BRIEF.md
# Winograd Input Tile Transform Array

This block applies the two-dimensional Winograd input transform for the 2x2-output, 3x3-filter case. It turns each 4x4 tile of signed feature-map samples into the 4x4 tile `Bt * D * B`. There is no multiplier in the datapath. A 4x4 grid of adder cells holds the transform coefficients fixed. Each cell's coefficient tells it to add its input to the running sum, subtract it, or pass the sum on unchanged. Every running sum starts at zero.

Samples arrive as 4-element columns. Each column is presented with a valid flag and accepted when the block is ready. After a restart, four columns build the first tile. The block keeps the newest two columns of each tile, so every two further columns complete the next tile, which overlaps the previous one by two columns.

Each tile makes two passes through the same grid:
- The first pass sends the four columns in and stores the column-transformed tile.
- The second pass sends the rows of that stored tile back in, which gives the final result without a separate transpose step.

The finished rows are collected and presented at the output as one tile with a single-cycle valid pulse.

Top module: `wino_in_xform`

## Requirements
- R1: While and right after reset, `in_ready` is 1, `out_valid` is 0 and `out_tile` is all zero.
- R2: The 1-D transform of a vector x is [x0-x2, x1+x2, x2-x1, x1-x3]. The result tile is computed in two steps. First, each column of D is transformed into column c of T. Then each row of T is transformed into row r of the result. Column element i sits at `in_col[8*i +: 8]`. Columns are numbered 0 (oldest) to 3 (newest). Result element (r,c) sits at `out_tile[10*(4*r+c) +: 10]`, as 10-bit two's complement.
- R3: Inputs are 8-bit signed. Tiles of all -128, all 127 and mixed extremes give exact results, with no overflow, in the 10-bit range.
- R4: After a column accepted with `in_restart`=1, the fourth accepted column completes a tile. After that, every second accepted column completes a tile whose columns 0 and 1 are columns 2 and 3 of the previous tile.
- R5: `in_ready` is 0 from the cycle after a tile's completing column is accepted until the cycle in which that tile's `out_valid` is high. In that cycle it is 1 again. Columns offered while `in_ready` is 0 are ignored and do not enter the tile.
- R6: `out_valid` is high for exactly one cycle. It rises 8 clock edges after the edge that accepts the completing column.
- R7: `out_tile` changes only in a cycle where `out_valid` is high, and holds its value between pulses.
- R8: A column accepted with `in_restart`=1 discards any partly collected columns and becomes column 0 of a new tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A column is offered |
| in_restart | input | 1 | Offered column begins a new strip |
| in_col | input | 32 | Four signed 8-bit samples, row i at bits 8i |
| in_ready | output | 1 | Block accepts a column this cycle |
| out_valid | output | 1 | One-cycle pulse: `out_tile` holds a new result |
| out_tile | output | 160 | Sixteen signed 10-bit results, element (r,c) at bits 10(4r+c) |

## Verification
Two events can fall in the same cycle: delivery of a finished tile and acceptance of the next column. This is because `in_ready` returns in the very cycle `out_valid` pulses. The bench keeps a column pending throughout every busy window, so the next column is taken at the edge right after the pulse. While the block is busy, the offered column is replaced with random garbage.

The bench judges the result in three ways:
- the delivered tile must still match the bench model;
- it must hold across that acceptance;
- no garbage column may appear in any later tile.

This checks both the overlap reuse and the ignore rule.

// File: rtl/wino_in_xform.sv
module wino_in_xform #(
  parameter int DW = 8,
  localparam int L  = 4,
  localparam int AW = DW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_restart,
  input  logic [L*DW-1:0]   in_col,
  output logic              in_ready,
  output logic              out_valid,
  output logic [L*L*AW-1:0] out_tile
);

  typedef enum logic [1:0] {OP_PASS = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2} op_t;

  function automatic op_t coef(int k, int i);
    case (k)
      0: coef = (i == 0) ? OP_ADD : (i == 2) ? OP_SUB : OP_PASS;
      1: coef = (i == 1 || i == 2) ? OP_ADD : OP_PASS;
      2: coef = (i == 2) ? OP_ADD : (i == 1) ? OP_SUB : OP_PASS;
      default: coef = (i == 1) ? OP_ADD : (i == 3) ? OP_SUB : OP_PASS;
    endcase
  endfunction

  logic signed [AW-1:0] win  [L][L];
  logic signed [AW-1:0] mid  [L][L];
  logic signed [AW-1:0] rows [L-1][L];
  logic signed [AW-1:0] outq [L][L];
  logic signed [AW-1:0] feed [L];
  logic signed [AW-1:0] xo   [L];
  logic       busy;
  logic [1:0] have;
  logic [2:0] cnt;
  logic       take;

  assign in_ready = ~busy;
  assign take     = in_valid & ~busy;

  always_comb begin
    for (int i = 0; i < L; i++)
      feed[i] = cnt[2] ? mid[cnt[1:0]][i] : win[cnt[1:0]][i];
  end

  always_comb begin
    for (int k = 0; k < L; k++) begin
      xo[k] = '0;
      for (int i = 0; i < L; i++) begin
        case (coef(k, i))
          OP_ADD:  xo[k] = xo[k] + feed[i];
          OP_SUB:  xo[k] = xo[k] - feed[i];
          default: xo[k] = xo[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      have      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        if (in_restart)        have <= 2'd1;
        else if (have == 2'd3) begin busy <= 1'b1; cnt <= '0; end
        else                   have <= have + 2'd1;
      end
      if (busy) begin
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          busy      <= 1'b0;
          have      <= 2'd2;
          out_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int c = 0; c < L-1; c++) win[c] <= win[c+1];
      for (int i = 0; i < L; i++)
        win[L-1][i] <= AW'($signed(in_col[i*DW +: DW]));
    end
    if (busy && !cnt[2]) begin
      for (int k = 0; k < L; k++) mid[k][cnt[1:0]] <= xo[k];
    end
    if (busy && cnt[2] && cnt != 3'd7) begin
      for (int k = 0; k < L; k++) rows[cnt[1:0]][k] <= xo[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < L; r++)
        for (int c = 0; c < L; c++) outq[r][c] <= '0;
    end else if (busy && cnt == 3'd7) begin
      for (int r = 0; r < L-1; r++) outq[r] <= rows[r];
      for (int c = 0; c < L; c++) outq[L-1][c] <= xo[c];
    end
  end

  for (genvar r = 0; r < L; r++) begin : g_or
    for (genvar c = 0; c < L; c++) begin : g_oc
      assign out_tile[(r*L+c)*AW +: AW] = outq[r][c];
    end
  end

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_ready_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
  assert_tile_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_restart && have == 2'd3) |=> !in_ready);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_tile));

endmodule

// File: tb/test_wino_in_xform.sv
module test_wino_in_xform;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_restart = 1'b0;
  logic [31:0]  in_col = '0;
  logic         in_ready;
  logic         out_valid;
  logic [159:0] out_tile;

  wino_in_xform i_wino_in_xform (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_restart(in_restart),
    .in_col(in_col), .in_ready(in_ready), .out_valid(out_valid), .out_tile(out_tile)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, acc_cyc = 0, bhave = 0;
  int bw [4][4];
  logic [159:0] exp_tile = '0, last_tile = '0;
  bit pending = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [159:0] act, logic [159:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [159:0] model();
    int t [4][4];
    int y [4][4];
    logic [159:0] v;
    for (int c = 0; c < 4; c++) begin
      t[0][c] = bw[c][0] - bw[c][2];
      t[1][c] = bw[c][1] + bw[c][2];
      t[2][c] = bw[c][2] - bw[c][1];
      t[3][c] = bw[c][1] - bw[c][3];
    end
    for (int r = 0; r < 4; r++) begin
      y[r][0] = t[r][0] - t[r][2];
      y[r][1] = t[r][1] + t[r][2];
      y[r][2] = t[r][2] - t[r][1];
      y[r][3] = t[r][1] - t[r][3];
    end
    v = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) v[(r*4+c)*10 +: 10] = y[r][c][9:0];
    return v;
  endfunction

  task automatic put(logic [31:0] col, bit rs);
    bit fin;
    in_restart = rs;
    in_valid = 1'b1;
    while (!in_ready) begin
      in_col = $urandom;
      @(negedge clk);
    end
    in_col = col;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_restart = 1'b0;
    for (int c = 0; c < 3; c++) bw[c] = bw[c+1];
    for (int i = 0; i < 4; i++) bw[3][i] = $signed(col[i*8 +: 8]);
    fin = 0;
    if (rs) bhave = 1;
    else if (bhave == 3) begin fin = 1; bhave = 2; end
    else bhave++;
    if (fin) begin
      exp_tile = model();
      pending = 1;
      acc_cyc = cyc;
      check(in_ready == 1'b0, "R5 ready low after completing column", {159'd0, in_ready}, 160'd0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        check(pending, "R6 pulse without pending tile", {159'd0, out_valid}, {159'd0, pending});
        check(cyc - acc_cyc == 8, "R6 latency", 160'(cyc - acc_cyc), 160'd8);
        check(out_tile == exp_tile, "R2 R3 R4 R8 tile value", out_tile, exp_tile);
        check(in_ready, "R5 ready with result", {159'd0, in_ready}, 160'd1);
        pending = 0;
        last_tile = out_tile;
      end else begin
        check(out_tile == last_tile, "R7 hold", out_tile, last_tile);
      end
    end
  end

  function automatic logic [31:0] fill(logic [7:0] v);
    return {v, v, v, v};
  endfunction

  task automatic wait_out();
    while (pending) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0 && out_tile == '0, "R1 reset state",
          {out_tile[157:0], out_valid, in_ready}, 160'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0 && out_tile == '0, "R1 after reset",
          {out_tile[157:0], out_valid, in_ready}, 160'd1);
    // R3: all minimum, all maximum, mixed extremes
    put(fill(8'h80), 1); repeat (3) put(fill(8'h80), 0); wait_out();
    put(fill(8'h7f), 1); repeat (3) put(fill(8'h7f), 0); wait_out();
    put(32'h807f807f, 1); put(32'h7f807f80, 0); put(32'h80807f7f, 0); put(32'h7f7f8080, 0);
    wait_out();
    // R8: restart discards a partly collected tile
    put(32'h11223344, 1); put(32'h55667788, 0);
    put(32'h01020304, 1); put(32'hf0e0d0c0, 0); put(32'h0a0b0c0d, 0); put(32'h7f00807f, 0);
    wait_out();
    // R4 R5: overlapping strip, next column pending during busy window
    put($urandom, 1); put($urandom, 0); put($urandom, 0); put($urandom, 0);
    for (int n = 0; n < 40; n++) begin
      put($urandom, 0);
      if (($urandom % 3) == 0) repeat ($urandom % 4) @(negedge clk);
    end
    wait_out();
    for (int s = 0; s < 10; s++) begin
      put($urandom, 1);
      for (int n = 0; n < 3 + 2 * ($urandom % 4); n++) put($urandom, 0);
      wait_out();
    end
    repeat (12) @(negedge clk);
    check(!pending, "R6 every tile delivered", {159'd0, pending}, 160'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule